// File: doc/BRIEF.md
# Backscatter Baseband Symbol Encoder

This block turns the serial bits of a tag reply into the baseband level that drives a backscatter modulator. A single datapath handles two line codes. The first is FM0, with one link-frequency period per bit. The second is Miller subcarrier coding, with 2, 4 or 8 subcarrier cycles per bit. The code is chosen at run time through a mode input. That mode is captured when a reply starts, so the code stays fixed for the whole reply.

Timing comes from a half-period enable, `hp_en`, which pulses at twice the link frequency. Each pulse is one half-cycle, called a tick. An FM0 bit lasts 2 ticks and a Miller bit lasts 2·M ticks. The level can change only on a tick. It toggles by default and stays put wherever the code calls for a phase inversion.

Bits arrive through a valid/ready handshake. `bit_ready` is offered only on the tick that begins a new symbol. If no bit is waiting at that tick, `busy` falls and the level holds. A `start` strobe opens a new reply: it samples the mode and clears the symbol position and the bit history. Preamble, pilot tone, end-of-signalling symbol and CRC are produced elsewhere.

Top module: `backscatter_encoder`

## Requirements
- R1: After reset, `mod_level` is 0, `busy` is 0, and `bit_ready` is 0 whenever `hp_en` is 0. The captured mode is FM0 and the previous-bit history is 1.
- R2: `mode` is sampled only on a cycle with `start` high, with 0=FM0, 1=Miller M=2, 2=Miller M=4 and 3=Miller M=8. Changing `mode` at any other time has no effect on the waveform.
- R3: In FM0, a symbol spans 2 ticks and `mod_level` inverts on the tick that accepts a bit.
- R4: In FM0, the second tick of a symbol inverts `mod_level` for a 0 and leaves it unchanged for a 1.
- R5: In Miller mode, a bit spans 2·M ticks and `mod_level` inverts on every tick of it, except at the two inversion points in R6 and R7.
- R6: In Miller mode, `mod_level` does not change on tick M of a bit whose value is 1 (the mid-bit phase inversion).
- R7: In Miller mode, `mod_level` does not change on the first tick of a 0 bit that follows a 0 bit. It does change on the first tick after any other pair of bits.
- R8: `bit_ready` is 1 exactly on an `hp_en` cycle, without `start`, at a symbol boundary. A bit is taken when `bit_valid` and `bit_ready` are both 1. `bit_valid` and `bit_data` are ignored at every other time.
- R9: `busy` rises when a bit is taken. If `bit_valid` is 0 at a boundary tick, `busy` falls and `mod_level` holds until a bit is taken.
- R10: `start` has priority over `hp_en`. It clears `busy` and the symbol position and sets the bit history to 1, and it leaves `mod_level` unchanged.
- R11: `mod_level` changes only on the clock edge that ends an `hp_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_en | input | 1 | Half-period enable, one pulse per half link cycle |
| start | input | 1 | Begin a reply: sample mode, clear history |
| mode | input | 2 | Line code: 0 FM0, 1/2/3 Miller M=2/4/8 |
| bit_valid | input | 1 | A reply bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | Boundary tick, the offered bit is taken |
| mod_level | output | 1 | Baseband level to the modulator |
| busy | output | 1 | A symbol is being sent |

## Verification
A wrong symbol position or a stale bit history shows on `mod_level` within one bit period. It appears as a missing or extra inversion at a boundary tick or at the mid-bit tick, and `bit_ready` then appears on the wrong tick. A wrong captured mode shows up as a symbol of the wrong length by the next boundary. An error in the busy state shows on the first boundary tick that finds no bit waiting. Every tick is compared against a bench model, and the idle gaps between ticks are checked for stability. Together these catch each of these faults within a few ticks.

// File: rtl/bsenc_pkg.sv
package bsenc_pkg;

   typedef enum logic [1:0] {
      ENC_FM0 = 2'b00,
      ENC_M2  = 2'b01,
      ENC_M4  = 2'b10,
      ENC_M8  = 2'b11
   } enc_mode_e;

   // subcarrier cycles per bit; FM0 counts as one link period
   function automatic int cycles_per_bit(enc_mode_e m);
      case (m)
         ENC_M2:  return 2;
         ENC_M4:  return 4;
         ENC_M8:  return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/enc_slot_timer.sv
// Tracks the tick position inside the current symbol.
module enc_slot_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             take,
   input  logic [CNT_W-1:0] half,
   output logic             at_edge,
   output logic             mid
);
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] last_pos;

   assign last_pos = CNT_W'({half, 1'b0} - {{CNT_W{1'b0}}, 1'b1});
   assign at_edge  = (pos == '0);
   assign mid      = (pos == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (clr) begin
         pos <= '0;
      end else if (step) begin
         if (at_edge) begin
            pos <= take ? CNT_W'(1) : '0;
         end else if (pos == last_pos) begin
            pos <= '0;
         end else begin
            pos <= pos + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/enc_bit_slot.sv
// Handshake at symbol boundaries, bit history and busy state.
module enc_bit_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic at_edge,
   input  logic valid,
   input  logic data,
   output logic ready,
   output logic take,
   output logic last_bit,
   output logic busy
);
   assign ready = step & at_edge;
   assign take  = ready & valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_bit <= 1'b1;
         busy     <= 1'b0;
      end else if (clr) begin
         last_bit <= 1'b1;
         busy     <= 1'b0;
      end else if (ready) begin
         busy <= valid;
         if (valid) last_bit <= data;
      end
   end
endmodule

// File: rtl/enc_level_gen.sv
// Toggles the level every tick unless an inversion point absorbs the toggle.
module enc_level_gen #(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic at_edge,
   input  logic take,
   input  logic mid,
   input  logic data,
   input  logic last_bit,
   input  logic miller,
   output logic level
);
   logic advance;
   logic hold;

   assign advance = take | (step & ~at_edge);
   // boundary: Miller 0 after 0; mid-bit: any code with a 1
   assign hold = at_edge ? (miller & ~last_bit & ~data) : (mid & last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= IDLE_LEVEL;
      end else if (advance && !hold) begin
         level <= ~level;
      end
   end
endmodule

// File: rtl/backscatter_encoder.sv
module backscatter_encoder
   import bsenc_pkg::*;
#(
   parameter int MAX_M      = 8,
   parameter bit MILLER_EN  = 1'b1,
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hp_en,
   input  logic       start,
   input  logic [1:0] mode,
   input  logic       bit_valid,
   input  logic       bit_data,
   output logic       bit_ready,
   output logic       mod_level,
   output logic       busy
);
   localparam int CNT_W = $clog2(MAX_M) + 1;

   generate
      if (!(MAX_M == 2 || MAX_M == 4 || MAX_M == 8)) begin : g_bad_max_m
         $error("backscatter_encoder: MAX_M must be 2, 4 or 8");
      end
   endgenerate

   enc_mode_e        mode_q;
   logic [CNT_W-1:0] half;
   logic             miller;
   logic             step;
   logic             at_edge;
   logic             mid;
   logic             take;
   logic             last_bit;

   assign step = hp_en & ~start;

   generate
      if (MILLER_EN) begin : g_multi_code
         int m_sel;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mode_q <= ENC_FM0;
            else if (start) mode_q <= enc_mode_e'(mode);
         end
         assign m_sel  = cycles_per_bit(mode_q);
         assign half   = CNT_W'((m_sel > MAX_M) ? MAX_M : m_sel);
         assign miller = (mode_q != ENC_FM0);
      end else begin : g_fm0_only
         assign mode_q = ENC_FM0;
         assign half   = CNT_W'(1);
         assign miller = 1'b0;
      end
   endgenerate

   enc_slot_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .step    (step),
      .take    (take),
      .half    (half),
      .at_edge (at_edge),
      .mid     (mid)
   );

   enc_bit_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .step     (step),
      .at_edge  (at_edge),
      .valid    (bit_valid),
      .data     (bit_data),
      .ready    (bit_ready),
      .take     (take),
      .last_bit (last_bit),
      .busy     (busy)
   );

   enc_level_gen #(.IDLE_LEVEL(IDLE_LEVEL)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .at_edge  (at_edge),
      .take     (take),
      .mid      (mid),
      .data     (bit_data),
      .last_bit (last_bit),
      .miller   (miller),
      .level    (mod_level)
   );
endmodule

// File: rtl/bsenc_checker.sv
module bsenc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       hp_en,
   input logic       start,
   input logic       bit_valid,
   input logic       bit_ready,
   input logic       mod_level,
   input logic       busy,
   input logic [1:0] mode_q
);
   p_level_only_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hp_en |=> $stable(mod_level));

   p_ready_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ready |-> (hp_en && !start));

   p_fm0_boundary_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && bit_ready && mode_q == 2'b00) |=> (mod_level != $past(mod_level)));

   p_busy_rise_on_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bit_valid && bit_ready));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(bit_valid && bit_ready)) |=> $stable(mod_level));

   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!busy && $stable(mod_level)));
endmodule

bind backscatter_encoder bsenc_checker u_bsenc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .hp_en     (hp_en),
   .start     (start),
   .bit_valid (bit_valid),
   .bit_ready (bit_ready),
   .mod_level (mod_level),
   .busy      (busy),
   .mode_q    (mode_q)
);

// File: tb/backscatter_encoder_test.sv
`timescale 1ns/1ps
module backscatter_encoder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hp_en = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic bit_valid = 1'b0;
   logic bit_data = 1'b0;
   logic bit_ready, mod_level, busy;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model of the expected state
   int   m_pos = 0;
   int   m_half = 1;
   bit   m_miller = 1'b0;
   logic m_last = 1'b1;
   logic m_level = 1'b0;
   logic m_busy = 1'b0;
   string tag_force = "";

   always #5 clk = ~clk;

   backscatter_encoder uut (
      .clk(clk), .rst_n(rst_n), .hp_en(hp_en), .start(start), .mode(mode),
      .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
      .mod_level(mod_level), .busy(busy)
   );

   function automatic int half_for(logic [1:0] m);
      case (m)
         2'd1: return 2;
         2'd2: return 4;
         2'd3: return 8;
         default: return 1;
      endcase
   endfunction

   task automatic chk(string req, logic act, logic exp, string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic do_start(logic [1:0] m);
      @(negedge clk);
      start = 1'b1; hp_en = 1'b1; mode = m;
      bit_valid = 1'b1; bit_data = $urandom_range(0, 1);
      #1 chk("R10", bit_ready, 1'b0, "ready during start");
      @(negedge clk);
      start = 1'b0; hp_en = 1'b0; bit_valid = 1'b0;
      m_pos = 0; m_last = 1'b1; m_busy = 1'b0;
      m_half = half_for(m); m_miller = (m != 2'd0);
      chk("R10", busy, 1'b0, "busy after start");
      chk("R10", mod_level, m_level, "level after start");
   endtask

   task automatic tick(logic v, logic d, int gap);
      logic  rdy;
      bit    tog;
      string tag;
      @(negedge clk);
      hp_en = 1'b1; bit_valid = v; bit_data = d;
      #1 rdy = bit_ready;
      chk("R8", rdy, (m_pos == 0), "bit_ready");
      if (m_pos == 0) begin
         if (v) begin
            tog = !(m_miller && !m_last && !d);
            tag = m_miller ? "R7" : "R3";
            m_last = d; m_busy = 1'b1; m_pos = 1;
         end else begin
            tog = 1'b0; tag = "R9"; m_busy = 1'b0;
         end
      end else begin
         if (m_pos == m_half) begin
            tog = !m_last;
            tag = m_miller ? "R6" : "R4";
         end else begin
            tog = 1'b1; tag = "R5";
         end
         m_pos = (m_pos == 2 * m_half - 1) ? 0 : m_pos + 1;
      end
      m_level = m_level ^ tog;
      if (tag_force != "") tag = tag_force;
      @(negedge clk);
      hp_en = 1'b0; bit_valid = 1'b0;
      chk(tag, mod_level, m_level, "mod_level");
      chk("R9", busy, m_busy, "busy");
      for (int g = 0; g < gap; g++) begin
         bit_valid = $urandom_range(0, 1);
         @(negedge clk);
         chk("R11", mod_level, m_level, "level between ticks");
      end
   endtask

   // one bit: offer until taken (optional underruns), then finish its symbol
   task automatic send_bit(logic d, bit allow_gap);
      while (1) begin
         bit v = allow_gap ? ($urandom_range(0, 9) != 0) : 1'b1;
         tick(v, d, $urandom_range(0, 2));
         if (v) break;
      end
      while (m_pos != 0) begin
         mode = $urandom_range(0, 3); // R2: ignored outside start
         tick($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", mod_level, 1'b0, "level in reset");
      chk("R1", busy, 1'b0, "busy in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", bit_ready, 1'b0, "ready without tick");
      chk("R1", mod_level, 1'b0, "level after reset");
      // default mode after reset is FM0 with history 1
      send_bit(1'b0, 1'b0);
      send_bit(1'b1, 1'b0);

      for (int m = 0; m < 4; m++) begin
         logic [7:0] pat = 8'b0011_0100;
         do_start(m[1:0]);
         for (int i = 0; i < 8; i++) send_bit(pat[i], 1'b0);
         send_bit(1'b0, 1'b0);
         send_bit(1'b0, 1'b0);
         for (int i = 0; i < 24; i++) send_bit($urandom_range(0, 1), 1'b1);
         tick(1'b0, 1'b0, 1); // underrun at boundary
         tick(1'b0, 1'b1, 0);
      end

      // R2: mode input change after start leaves the reply code alone
      do_start(2'd2);
      mode = 2'd0;
      tag_force = "R2";
      send_bit(1'b1, 1'b0);
      send_bit(1'b0, 1'b0);
      tag_force = "";

      // R10: start in the middle of a symbol restores boundary and history
      do_start(2'd1);
      send_bit(1'b0, 1'b0);
      tick(1'b1, 1'b0, 0);
      tick(1'b0, 1'b0, 0);
      do_start(2'd1);
      tag_force = "R10";
      send_bit(1'b0, 1'b0); // history 1: boundary toggles
      tag_force = "";

      for (int r = 0; r < 6; r++) begin
         do_start($urandom_range(0, 3));
         for (int i = 0; i < 20; i++) send_bit($urandom_range(0, 1), 1'b1);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule